// File: doc/BRIEF.md
# Parity-Checked Pixel Receiver with Last-Good Hold

This block sits behind a serial link deserializer and takes one 30-bit pixel word per pixel-clock cycle, marked by a valid strobe. It splits the word into 8-bit red, green and blue, active-low horizontal and vertical sync, active-high data enable and two auxiliary bits. It checks odd parity over the colour and sync fields together with the received parity bit.

A word that passes is registered to the outputs and becomes the new reference pixel. A word that fails raises a registered error flag for that pixel, and the outputs repeat the last pixel that passed, aux bits included. A display therefore never sees a corrupted colour or sync value. Cycles without the strobe leave the outputs untouched.

Word layout, bit 0 first: blue [7:0], green [15:8], red [23:16], hsync_n [24], vsync_n [25], de [26], aux [28:27], parity [29].

Top module: `pxr_rx_hold`

## Requirements
- R1: A strobed word with good parity appears on the outputs one clock later, with the fields split as in the word layout above and the error flag low.
- R2: Parity is good when the XOR of bits [26:0] and bit 29 is 1. A strobed word with bad parity sets perr_o high in the next cycle, for exactly one cycle per bad word.
- R3: The aux bits [28:27] are not covered by parity. Changing them alone never raises perr_o.
- R4: When a strobed word has bad parity, every output field, aux included, shows the last good pixel.
- R5: Consecutive bad words keep showing the same last good pixel, and perr_o stays high for each of them.
- R6: While reset is held, colour and aux outputs are 0, hsync_n_o and vsync_n_o are 1, and de_o and perr_o are 0.
- R7: In a cycle without word_vld, the outputs keep their values in the next cycle and perr_o is 0, whatever the parity of word_in.
- R8: A bad word before any good word outputs the reset pixel of R6, with perr_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_vld | input | 1 | Strobe: word_in holds a pixel this cycle |
| word_in | input | 30 | Deserialized pixel word |
| red_o | output | 8 | Red channel |
| grn_o | output | 8 | Green channel |
| blu_o | output | 8 | Blue channel |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| de_o | output | 1 | Data enable, active high |
| aux_o | output | 2 | Auxiliary bits |
| perr_o | output | 1 | Parity error for the pixel now on the outputs |

## Verification
In one cycle the block both raises the error flag and decides which pixel to show: the stored good pixel or the reset default. The bench provokes this with a bad word as the very first word after reset, and with the runs good, bad, bad, good. It also sends bad-parity words while the strobe is low. A scoreboard model tracks the last good pixel on its own, and each output cycle is judged on the flag and on every field together.

// File: rtl/pxr_pkg.sv
package pxr_pkg;

   localparam int unsigned PXR_COLOR_W = 8;
   localparam int unsigned PXR_AUX_W   = 2;

   typedef enum logic {
      PAR_REDUCE = 1'b0,
      PAR_TREE   = 1'b1
   } par_style_e;

   function automatic int unsigned pxr_word_w(input int unsigned cw, input int unsigned aw);
      return 3 * cw + 3 + aw + 1;
   endfunction

endpackage

// File: rtl/pxr_unpack.sv
module pxr_unpack #(
   parameter int unsigned COLOR_W = pxr_pkg::PXR_COLOR_W,
   parameter int unsigned AUX_W   = pxr_pkg::PXR_AUX_W,
   localparam int unsigned CB     = 3 * COLOR_W,
   localparam int unsigned COV_W  = CB + 3,
   localparam int unsigned WORD_W = pxr_pkg::pxr_word_w(COLOR_W, AUX_W)
) (
   input  logic [WORD_W-1:0] word_i,
   output logic [COV_W-1:0]  cov_o,
   output logic [AUX_W-1:0]  aux_o,
   output logic              par_o
);

   localparam int unsigned AUX_LO  = COV_W;
   localparam int unsigned PAR_BIT = AUX_LO + AUX_W;

   if (COLOR_W < 1) begin : g_bad_cw
      $error("pxr_unpack: COLOR_W must be at least 1");
   end
   if (AUX_W < 1) begin : g_bad_aw
      $error("pxr_unpack: AUX_W must be at least 1");
   end
   if (PAR_BIT != WORD_W - 1) begin : g_bad_layout
      $error("pxr_unpack: parity bit must be the top bit of the word");
   end

   assign cov_o = word_i[COV_W-1:0];
   assign aux_o = word_i[PAR_BIT-1:AUX_LO];
   assign par_o = word_i[PAR_BIT];

endmodule

// File: rtl/pxr_parity.sv
module pxr_parity #(
   parameter int unsigned         N     = 27,
   parameter pxr_pkg::par_style_e STYLE = pxr_pkg::PAR_TREE
) (
   input  logic [N-1:0] bits_i,
   input  logic         par_i,
   output logic         ok_o
);

   localparam int unsigned LEAVES = N + 1;
   localparam int unsigned LVLS   = (LEAVES > 1) ? $clog2(LEAVES) : 1;
   localparam int unsigned P      = 1 << LVLS;

   if (N < 1) begin : g_bad_n
      $error("pxr_parity: N must be at least 1");
   end

   if (STYLE == pxr_pkg::PAR_REDUCE) begin : g_reduce
      assign ok_o = ^{bits_i, par_i};
   end else begin : g_tree
      logic [2*P-1:1] node;
      for (genvar l = 0; l < P; l++) begin : g_leaf
         if (l < N) begin : g_bit
            assign node[P+l] = bits_i[l];
         end else if (l == N) begin : g_par
            assign node[P+l] = par_i;
         end else begin : g_pad
            assign node[P+l] = 1'b0;
         end
      end
      for (genvar i = 1; i < P; i++) begin : g_node
         assign node[i] = node[2*i] ^ node[2*i+1];
      end
      assign ok_o = node[1];
   end

endmodule

// File: rtl/pxr_hold.sv
module pxr_hold #(
   parameter int unsigned   W       = 29,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld_i,
   input  logic         ok_i,
   input  logic [W-1:0] data_i,
   output logic [W-1:0] data_o,
   output logic         err_o
);

   logic [W-1:0] keep_q;
   logic         err_q;
   logic         take;

   if (W < 1) begin : g_bad_w
      $error("pxr_hold: W must be at least 1");
   end

   assign take = vld_i & ok_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= RST_VAL;
         err_q  <= 1'b0;
      end else begin
         err_q <= vld_i & ~ok_i;
         if (take) begin
            keep_q <= data_i;
         end
      end
   end

   assign data_o = keep_q;
   assign err_o  = err_q;

endmodule

// File: rtl/pxr_rx_hold.sv
module pxr_rx_hold #(
   parameter int unsigned         COLOR_W   = pxr_pkg::PXR_COLOR_W,
   parameter int unsigned         AUX_W     = pxr_pkg::PXR_AUX_W,
   parameter pxr_pkg::par_style_e PAR_STYLE = pxr_pkg::PAR_TREE,
   localparam int unsigned        WORD_W    = pxr_pkg::pxr_word_w(COLOR_W, AUX_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_vld,
   input  logic [WORD_W-1:0]  word_in,
   output logic [COLOR_W-1:0] red_o,
   output logic [COLOR_W-1:0] grn_o,
   output logic [COLOR_W-1:0] blu_o,
   output logic               hsync_n_o,
   output logic               vsync_n_o,
   output logic               de_o,
   output logic [AUX_W-1:0]   aux_o,
   output logic               perr_o
);

   localparam int unsigned CB    = 3 * COLOR_W;
   localparam int unsigned COV_W = CB + 3;
   localparam int unsigned DW    = COV_W + AUX_W;
   localparam logic [DW-1:0] RST_PIX = {{(AUX_W + 1){1'b0}}, 2'b11, {CB{1'b0}}};

   logic [COV_W-1:0] cov;
   logic [AUX_W-1:0] aux_in;
   logic             par_bit;
   logic             par_ok;
   logic [DW-1:0]    pix_q;

   pxr_unpack #(
      .COLOR_W (COLOR_W),
      .AUX_W   (AUX_W)
   ) u_unpack (
      .word_i (word_in),
      .cov_o  (cov),
      .aux_o  (aux_in),
      .par_o  (par_bit)
   );

   pxr_parity #(
      .N     (COV_W),
      .STYLE (PAR_STYLE)
   ) u_parity (
      .bits_i (cov),
      .par_i  (par_bit),
      .ok_o   (par_ok)
   );

   pxr_hold #(
      .W       (DW),
      .RST_VAL (RST_PIX)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .vld_i  (word_vld),
      .ok_i   (par_ok),
      .data_i ({aux_in, cov}),
      .data_o (pix_q),
      .err_o  (perr_o)
   );

   assign blu_o     = pix_q[COLOR_W-1:0];
   assign grn_o     = pix_q[2*COLOR_W-1:COLOR_W];
   assign red_o     = pix_q[CB-1:2*COLOR_W];
   assign hsync_n_o = pix_q[CB];
   assign vsync_n_o = pix_q[CB+1];
   assign de_o      = pix_q[CB+2];
   assign aux_o     = pix_q[DW-1:COV_W];

endmodule

// File: rtl/pxr_rx_hold_chk.sv
module pxr_rx_hold_chk #(
   parameter int unsigned  COLOR_W = 8,
   parameter int unsigned  AUX_W   = 2,
   localparam int unsigned WORD_W  = 3 * COLOR_W + 3 + AUX_W + 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               word_vld,
   input logic [WORD_W-1:0]  word_in,
   input logic [COLOR_W-1:0] red_o,
   input logic [COLOR_W-1:0] grn_o,
   input logic [COLOR_W-1:0] blu_o,
   input logic               hsync_n_o,
   input logic               vsync_n_o,
   input logic               de_o,
   input logic [AUX_W-1:0]   aux_o,
   input logic               perr_o
);

   localparam int unsigned CB = 3 * COLOR_W;

   logic                  good_in;
   logic [WORD_W-2:0]     shown;

   assign good_in = ^{word_in[CB+2:0], word_in[WORD_W-1]};
   assign shown   = {aux_o, de_o, vsync_n_o, hsync_n_o, red_o, grn_o, blu_o};

   p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && good_in) |=> (shown == $past(word_in[WORD_W-2:0])) && !perr_o);

   p_flag_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && !good_in) |=> perr_o);

   p_flag_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |-> ($past(word_vld) && !$past(good_in)));

   p_hold_bad_r4: assert property (@(posedge clk) disable iff (!rst_n)
      perr_o |-> $stable(shown));

   p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> ($stable(shown) && !perr_o));

   always @(negedge clk) begin
      if (!rst_n) begin
         a_reset_r6: assert (shown == {{(AUX_W + 1){1'b0}}, 2'b11, {CB{1'b0}}} && !perr_o);
      end
   end

endmodule

bind pxr_rx_hold pxr_rx_hold_chk #(
   .COLOR_W (COLOR_W),
   .AUX_W   (AUX_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .word_vld  (word_vld),
   .word_in   (word_in),
   .red_o     (red_o),
   .grn_o     (grn_o),
   .blu_o     (blu_o),
   .hsync_n_o (hsync_n_o),
   .vsync_n_o (vsync_n_o),
   .de_o      (de_o),
   .aux_o     (aux_o),
   .perr_o    (perr_o)
);

// File: tb/tb_pxr_rx_hold.sv
`timescale 1ns/1ps
module tb_pxr_rx_hold;

   typedef struct {
      logic [29:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        word_vld = 1'b0;
   logic [29:0] word_in = '0;
   logic [7:0]  red_o, grn_o, blu_o;
   logic        hsync_n_o, vsync_n_o, de_o, perr_o;
   logic [1:0]  aux_o;

   int   n_cmp = 0;
   int   n_bad = 0;
   int   wd = 0;
   bit   done = 0;
   item_t q[$];
   logic [28:0] last_good = {3'b000, 2'b11, 24'h0};

   always #2.5 clk = ~clk;

   pxr_rx_hold dut (
      .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
      .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o),
      .hsync_n_o(hsync_n_o), .vsync_n_o(vsync_n_o), .de_o(de_o),
      .aux_o(aux_o), .perr_o(perr_o)
   );

   function automatic logic [29:0] actual();
      return {perr_o, aux_o, de_o, vsync_n_o, hsync_n_o, red_o, grn_o, blu_o};
   endfunction

   // sync = {de, vs_n, hs_n}; bad=1 flips the parity bit
   function automatic logic [29:0] mk(logic [23:0] rgb, logic [2:0] sync,
                                      logic [1:0] aux, bit bad);
      logic p;
      p = ~(^{sync, rgb}) ^ bad;
      return {p, aux, sync, rgb};
   endfunction

   task automatic compare(logic [29:0] got, logic [29:0] exp, string tag);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic send(logic [29:0] w, bit v, string tag);
      item_t it;
      bit ok;
      @(negedge clk);
      word_in  = w;
      word_vld = v;
      ok = ^{w[26:0], w[29]};
      if (v && ok) last_good = w[28:0];
      it.exp = {v && !ok, last_good};
      it.tag = tag;
      q.push_back(it);
   endtask

   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         compare(actual(), it.exp, it.tag);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      wd++;
      if (wd > 20000) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      compare(actual(), {1'b0, 2'b00, 3'b011, 24'h0}, "R6");
      @(negedge clk);
      rst_n = 1'b1;

      // R8: bad word before any good word shows the reset pixel
      send(mk(24'hA5C33C, 3'b100, 2'b11, 1), 1, "R8");
      // R1: good words
      send(mk(24'h123456, 3'b111, 2'b01, 0), 1, "R1");
      send(mk(24'hFFFFFF, 3'b100, 2'b10, 0), 1, "R1");
      send(mk(24'h000001, 3'b010, 2'b00, 0), 1, "R1");
      // R3: only aux changes, parity still good
      send(mk(24'h000001, 3'b010, 2'b11, 0), 1, "R3");
      send(mk(24'h000001, 3'b010, 2'b01, 0), 1, "R3");
      // R4: bad word after good, aux differs
      send(mk(24'hDEADBE, 3'b101, 2'b10, 1), 1, "R4");
      // R5: consecutive bad words
      send(mk(24'h0F0F0F, 3'b001, 2'b00, 1), 1, "R5");
      send(mk(24'hF0F0F0, 3'b110, 2'b11, 1), 1, "R5");
      send(mk(24'h777777, 3'b111, 2'b10, 0), 1, "R1");
      // R7: no strobe, good and bad words on the input
      send(mk(24'h999999, 3'b000, 2'b01, 0), 0, "R7");
      send(mk(24'h888888, 3'b000, 2'b00, 1), 0, "R7");
      send(mk(24'h888888, 3'b000, 2'b00, 1), 1, "R2");
      send(mk(24'h888888, 3'b000, 2'b00, 1), 0, "R7");
      // R2: random mix
      for (int i = 0; i < 300; i++) begin
         logic [29:0] w;
         w = mk($urandom, $urandom, $urandom, ($urandom % 4) == 0);
         send(w, ($urandom % 5) != 0, "R2");
      end
      send('0, 0, "R7");
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule